// File: doc/BRIEF.md
# Per-Beat Priority Arbiter for DMA Channels

This block decides which of a set of DMA channels owns the shared bus for the next beat. A beat is one bus access, and it is also a whole burst, so the choice is made again after every beat. Each channel keeps one request flag. A software strobe or a hardware strobe sets the flag, and the flag clears when the channel's engine reports that the unit of work named by the channel's trigger action has finished. That unit is a single beat, a block or a full transaction. The channel engines move the data. The arbiter only grants the bus.

Each channel carries a two-bit level from 0 to 3, and 3 is the most urgent. The arbiter serves the most urgent level that has an eligible request. Inside that level it rotates, starting with the channel after the one it last granted at that level. A suspended channel still gathers strobes into its flag but takes no part in arbitration until it is resumed. Disabling a channel drops its flag, and it also drops its grant if the channel holds one. The grant is a registered one-hot vector with a matching index, and it stays up until the engine signals that the beat is done.

Top module: `dma_beat_arbiter`

## Requirements
- R1: After reset no grant is asserted, `grant_valid` is 0, `grant_idx` is 0 and every request flag is clear. The round-robin pointer of each level starts at channel NCH-1, so channel 0 is the first one tried.
- R2: A strobe on `sw_trig[c]` or `hw_trig[c]` sets the request flag of channel c at the next clock edge when `ch_enable[c]` is 1. A strobe on a disabled channel is ignored. Strobes that arrive while the flag is already set add no further request, so the channel gets only one grant.
- R3: While no grant is held, a channel that is pending, enabled and not suspended at a clock edge is granted at that edge. A strobe therefore appears as a grant two edges after it is sampled. `grant` is one-hot and `grant_idx` holds its bit position.
- R4: When channels at different levels are eligible, the grant goes to the highest `ch_level` value (two bits per channel at `ch_level[2c+1:2c]`, 3 most urgent).
- R5: Among eligible channels of the winning level, the grant goes to the first channel found by counting upward with wraparound from the channel last granted at that level. Each level keeps its own pointer.
- R6: A channel with `ch_suspend[c]` at 1 is never newly granted, but it keeps its flag and accepts strobes. Once it is resumed it competes normally.
- R7: A grant holds steady until `beat_done` is sampled high. It is gone at the next edge, and at least one clock passes with no grant before the next grant.
- R8: The request flag clears on the `beat_done` that ends the channel's trigger-action unit. `ch_action[2c+1:2c]` encodes the unit: 0 means every beat, 1 means a beat with `beat_block_end`, and 2 or 3 means a beat with `beat_xact_end`. In every other case the channel requests again.
- R9: Clearing `ch_enable[c]` clears channel c's flag at the next edge. If channel c holds the grant, the grant is released at that same edge.
- R10: A strobe sampled at the same edge as the `beat_done` that ends a unit leaves the flag set, so the channel is granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_enable | input | NCH | Per-channel enable |
| ch_suspend | input | NCH | Per-channel suspend, removes the channel from arbitration |
| ch_level | input | 2*NCH | Per-channel priority level, two bits each |
| ch_action | input | 2*NCH | Per-channel trigger-action unit, two bits each |
| sw_trig | input | NCH | Software request strobes |
| hw_trig | input | NCH | Peripheral or event request strobes |
| beat_done | input | 1 | The granted channel's beat has finished |
| beat_block_end | input | 1 | The finished beat was the last of its block |
| beat_xact_end | input | 1 | The finished beat was the last of its transaction |
| grant | output | NCH | One-hot grant |
| grant_valid | output | 1 | A grant is held |
| grant_idx | output | clog2(NCH) | Index of the granted channel, 0 when idle |

## Verification
The arbiter is tested with several request patterns. Simultaneous requests at one level show whether rotation starts at the right place and wraps correctly. Mixed levels separate strict level priority from rotation. Repeated and overlapping strobes show whether duplicates are absorbed or counted. Block and transaction modes show whether the flag clears at the right `beat_done`. Suspend, mid-grant disable and a strobe coinciding with completion each exercise a different path through the flag and grant logic, and a long-held grant shows that the grant never moves before `beat_done`.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
    localparam int LVLS = 4;
    localparam int LVLW = 2;

    typedef enum logic [1:0] {
        ACT_BEAT     = 2'd0,
        ACT_BLOCK    = 2'd1,
        ACT_XACT     = 2'd2,
        ACT_XACT_ALT = 2'd3
    } act_e;
endpackage

// File: rtl/dmarb_pend.sv
module dmarb_pend #(
    parameter int NCH = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] sw,
    input  logic [NCH-1:0] hw,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] pend
);
    typedef struct packed {
        logic [NCH-1:0] req;
    } pend_st_t;

    pend_st_t st_d, st_q;

    // set has priority over clear, disable overrides both
    always_comb begin
        st_d     = st_q;
        st_d.req = en & ((st_q.req & ~clr) | sw | hw);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.req;

    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (~en != '0) |=> ((pend & ~$past(en)) == '0)); // R9
    AST_TRIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (((sw | hw) & en) != '0) |=> ((pend & $past((sw | hw) & en)) == $past((sw | hw) & en))); // R2
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~sw & ~hw) != '0) |=> ((pend & $past(clr & ~sw & ~hw)) == '0)); // R8
endmodule

// File: rtl/dmarb_pick.sv
module dmarb_pick
    import dmarb_pkg::*;
#(
    parameter int NCH = 12,
    parameter int IW  = 4
) (
    input  logic [NCH-1:0]     elig,
    input  logic [2*NCH-1:0]   prio,
    input  logic [LVLS*IW-1:0] last_flat,
    output logic               found,
    output logic [IW-1:0]      win,
    output logic [LVLW-1:0]    win_lvl
);
    logic [LVLS-1:0][NCH-1:0] lvl_mask;

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign lvl_mask[l][c] = elig[c] & (prio[2*c +: 2] == LVLW'(l));
        end
    end

    logic [LVLW-1:0] top_lvl;
    logic [IW-1:0]   start;

    always_comb begin
        top_lvl = '0;
        for (int l = 0; l < LVLS; l++) begin
            if (|lvl_mask[l]) top_lvl = LVLW'(l);
        end
        start = last_flat[int'(top_lvl)*IW +: IW];
    end

    always_comb begin
        int cand;
        cand  = 0;
        found = 1'b0;
        win   = '0;
        for (int off = 1; off <= NCH; off++) begin
            cand = int'(start) + off;
            if (cand >= NCH) cand = cand - NCH;
            if (!found && lvl_mask[top_lvl][cand]) begin
                found = 1'b1;
                win   = IW'(cand);
            end
        end
    end

    assign win_lvl = top_lvl;
endmodule

// File: rtl/dma_beat_arbiter.sv
module dma_beat_arbiter
    import dmarb_pkg::*;
#(
    parameter int NCH = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         ch_enable,
    input  logic [NCH-1:0]         ch_suspend,
    input  logic [2*NCH-1:0]       ch_level,
    input  logic [2*NCH-1:0]       ch_action,
    input  logic [NCH-1:0]         sw_trig,
    input  logic [NCH-1:0]         hw_trig,
    input  logic                   beat_done,
    input  logic                   beat_block_end,
    input  logic                   beat_xact_end,
    output logic [NCH-1:0]         grant,
    output logic                   grant_valid,
    output logic [$clog2(NCH)-1:0] grant_idx
);
    localparam int IW = $clog2(NCH);

    typedef struct packed {
        logic                     busy;
        logic [IW-1:0]            idx;
        logic [LVLS-1:0][IW-1:0]  last;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NCH-1:0]  pend, elig, clr, unit_end, hi;
    logic            found;
    logic [IW-1:0]   win;
    logic [LVLW-1:0] win_lvl;

    assign elig = pend & ch_enable & ~ch_suspend;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [1:0] act;
        assign act         = ch_action[2*c +: 2];
        assign unit_end[c] = (act == ACT_BEAT)
                           | ((act == ACT_BLOCK) & beat_block_end)
                           | (act[1] & beat_xact_end);
        assign clr[c]      = st_q.busy & beat_done & (st_q.idx == IW'(c)) & unit_end[c];
        assign hi[c]       = elig[c] & (ch_level[2*c +: 2] > win_lvl);
    end

    dmarb_pend #(.NCH(NCH)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ch_enable),
        .sw   (sw_trig),
        .hw   (hw_trig),
        .clr  (clr),
        .pend (pend)
    );

    dmarb_pick #(.NCH(NCH), .IW(IW)) u_pick (
        .elig     (elig),
        .prio     (ch_level),
        .last_flat(st_q.last),
        .found    (found),
        .win      (win),
        .win_lvl  (win_lvl)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (beat_done || !ch_enable[st_q.idx]) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end
        end else if (found) begin
            st_d.busy          = 1'b1;
            st_d.idx           = win;
            st_d.last[win_lvl] = win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.idx  <= '0;
            for (int l = 0; l < LVLS; l++) st_q.last[l] <= IW'(NCH - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid = st_q.busy;
    assign grant_idx   = st_q.idx;
    assign grant       = st_q.busy ? (NCH'(1) << st_q.idx) : '0;

    AST_NEW_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> ((grant & $past(pend & ch_enable & ~ch_suspend)) != '0)); // R6
    AST_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> !$past(|hi)); // R4
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !beat_done && ch_enable[grant_idx]) |=> (grant_valid && $stable(grant))); // R7
    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && beat_done) |=> !grant_valid); // R7
    AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !ch_enable[grant_idx]) |=> !grant_valid); // R9
endmodule

// File: tb/tb_dma_beat_arbiter.sv
`timescale 1ns/1ps
module tb_dma_beat_arbiter;
    localparam int NCH = 12;
    localparam int IW  = $clog2(NCH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0]   en, susp, sw, hw;
    logic [2*NCH-1:0] lvl, act;
    logic bd, be, xe;
    logic [NCH-1:0] gnt;
    logic           gnt_valid;
    logic [IW-1:0]  gnt_idx;

    always #4 clk = ~clk;

    dma_beat_arbiter #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .ch_enable(en), .ch_suspend(susp),
        .ch_level(lvl), .ch_action(act), .sw_trig(sw), .hw_trig(hw),
        .beat_done(bd), .beat_block_end(be), .beat_xact_end(xe),
        .grant(gnt), .grant_valid(gnt_valid), .grant_idx(gnt_idx)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string phase = "R1";

    task automatic chk(input bit ok, input string tag, input string what, input int a, input int e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, a, e);
        end
    endtask

    // reference model, updated at each rising edge
    bit m_pend[NCH];
    int m_last[4];
    bit m_busy;
    int m_idx;

    always @(posedge clk) begin
        bit ob, found, cl;
        int oi, c, a;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) m_pend[i] = 0;
            for (int l = 0; l < 4; l++) m_last[l] = NCH - 1;
            m_busy = 0;
            m_idx = 0;
        end else begin
            ob = m_busy;
            oi = m_idx;
            found = 0;
            if (ob) begin
                if (bd || !en[oi]) begin
                    m_busy = 0;
                    m_idx = 0;
                end
            end else begin
                for (int l = 3; l >= 0; l--) begin
                    for (int k = 1; k <= NCH; k++) begin
                        c = (m_last[l] + k) % NCH;
                        if (!found && m_pend[c] && en[c] && !susp[c] && int'(lvl[2*c +: 2]) == l) begin
                            found = 1;
                            m_busy = 1;
                            m_idx = c;
                            m_last[l] = c;
                        end
                    end
                end
            end
            for (int i = 0; i < NCH; i++) begin
                a = int'(act[2*i +: 2]);
                cl = ob && bd && oi == i && (a == 0 || (a == 1 && be) || (a >= 2 && xe));
                m_pend[i] = en[i] && ((m_pend[i] && !cl) || sw[i] || hw[i]);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(gnt_valid == m_busy, phase, "grant_valid vs model", int'(gnt_valid), int'(m_busy));
            chk(int'(gnt) == (m_busy ? (1 << m_idx) : 0), phase, "grant vs model",
                int'(gnt), m_busy ? (1 << m_idx) : 0);
            chk(int'(gnt_idx) == m_idx, phase, "grant_idx vs model", int'(gnt_idx), m_idx);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        sw = m;
        tick();
        sw = '0;
    endtask

    task automatic wait_grant(output int got);
        int n = 0;
        while (!gnt_valid && n < 30) begin
            tick();
            n++;
        end
        got = gnt_valid ? int'(gnt_idx) : -1;
    endtask

    task automatic serve(output int got, input bit blk, input bit xct);
        wait_grant(got);
        bd = 1; be = blk; xe = xct;
        tick();
        bd = 0; be = 0; xe = 0;
    endtask

    task automatic expect_serve(input int e, input string tag, input bit blk, input bit xct);
        int got;
        serve(got, blk, xct);
        chk(got == e, tag, "granted channel", got, e);
    endtask

    task automatic idle_for(input int n, input string tag);
        repeat (n) begin
            tick();
            chk(!gnt_valid, tag, "no grant expected", int'(gnt_valid), 0);
        end
    endtask

    initial begin
        int got;
        en = '1; susp = '0; sw = '0; hw = '0; lvl = '0; act = '0;
        bd = 0; be = 0; xe = 0;
        repeat (3) tick();
        // R1 reset state
        chk(!gnt_valid && gnt == '0 && gnt_idx == '0, "R1", "outputs in reset", int'(gnt), 0);
        rst_n = 1;
        tick();
        chk(!gnt_valid && gnt == '0 && gnt_idx == '0, "R1", "outputs after reset", int'(gnt), 0);

        // R3 latency, R5 order from reset pointer
        phase = "R3";
        sw = (NCH'(1) << 3) | (NCH'(1) << 5) | (NCH'(1) << 9);
        tick();
        sw = '0;
        chk(!gnt_valid, "R3", "no grant one edge after strobe", int'(gnt_valid), 0);
        tick();
        chk(gnt_valid && gnt_idx == 3, "R3", "grant two edges after strobe", int'(gnt_idx), 3);
        phase = "R5";
        expect_serve(3, "R5", 0, 0);
        expect_serve(5, "R5", 0, 0);
        expect_serve(9, "R5", 0, 0);
        idle_for(4, "R8");

        // R2 duplicate strobes absorbed, disabled strobe ignored
        phase = "R2";
        sw = NCH'(1) << 2;
        tick();
        hw = NCH'(1) << 2;
        tick();
        hw = '0;
        tick();
        sw = '0;
        expect_serve(2, "R2", 0, 0);
        idle_for(5, "R2");
        en[4] = 0;
        pulse(NCH'(1) << 4);
        en[4] = 1;
        idle_for(5, "R2");

        // R4 levels: ch7=3, ch10=2, ch1=1, ch0=0
        phase = "R4";
        lvl[2*7 +: 2] = 2'd3;
        lvl[2*10 +: 2] = 2'd2;
        lvl[2*1 +: 2] = 2'd1;
        pulse((NCH'(1) << 0) | (NCH'(1) << 1) | (NCH'(1) << 7) | (NCH'(1) << 10));
        expect_serve(7, "R4", 0, 0);
        expect_serve(10, "R4", 0, 0);
        expect_serve(1, "R4", 0, 0);
        expect_serve(0, "R4", 0, 0);
        lvl = '0;

        // R5 rotation resumes after last level-0 grant (ch0) and wraps
        phase = "R5";
        pulse((NCH'(1) << 0) | (NCH'(1) << 6) | (NCH'(1) << 11));
        expect_serve(6, "R5", 0, 0);
        expect_serve(11, "R5", 0, 0);
        expect_serve(0, "R5", 0, 0);

        // R6 suspended channel keeps its flag but is skipped
        phase = "R6";
        susp[4] = 1;
        pulse((NCH'(1) << 4) | (NCH'(1) << 8));
        expect_serve(8, "R6", 0, 0);
        idle_for(5, "R6");
        susp[4] = 0;
        expect_serve(4, "R6", 0, 0);

        // R8 block and transaction units
        phase = "R8";
        act[2*5 +: 2] = 2'd1;
        pulse(NCH'(1) << 5);
        expect_serve(5, "R8", 0, 0);
        expect_serve(5, "R8", 0, 0);
        expect_serve(5, "R8", 1, 0);
        idle_for(4, "R8");
        act[2*5 +: 2] = 2'd2;
        pulse(NCH'(1) << 5);
        expect_serve(5, "R8", 1, 0);
        expect_serve(5, "R8", 0, 1);
        idle_for(4, "R8");
        act = '0;

        // R9 disable while granted
        phase = "R9";
        pulse(NCH'(1) << 3);
        wait_grant(got);
        chk(got == 3, "R9", "granted channel", got, 3);
        en[3] = 0;
        tick();
        chk(!gnt_valid, "R9", "grant dropped on disable", int'(gnt_valid), 0);
        en[3] = 1;
        idle_for(4, "R9");

        // R10 strobe on completing beat re-requests
        phase = "R10";
        pulse(NCH'(1) << 2);
        wait_grant(got);
        chk(got == 2, "R10", "granted channel", got, 2);
        bd = 1;
        sw = NCH'(1) << 2;
        tick();
        bd = 0;
        sw = '0;
        expect_serve(2, "R10", 0, 0);
        idle_for(3, "R10");

        // R7 grant held until beat_done, then one idle clock
        phase = "R7";
        pulse((NCH'(1) << 1) | (NCH'(1) << 9));
        wait_grant(got);
        chk(got == 9, "R7", "granted channel", got, 9);
        repeat (4) begin
            tick();
            chk(gnt_valid && gnt_idx == 9, "R7", "grant held", int'(gnt_idx), 9);
        end
        bd = 1;
        tick();
        bd = 0;
        chk(!gnt_valid, "R7", "gap after beat_done", int'(gnt_valid), 0);
        expect_serve(1, "R7", 0, 0);
        idle_for(3, "R7");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule